// File: doc/BRIEF.md
# Single-Frame Capture Arming Controller

This block lets a processor or upstream sequencer grab exactly one complete camera frame into an external frame FIFO. A one-cycle capture request arms the block. The FIFO write-enable opens only on the next frame-sync rising edge, and it closes on the frame-sync rising edge after that. The frame-sync and line-valid inputs come from the camera's clock domain, so each passes through a synchroniser chain and a rising-edge detector before use.

Progress is reported by a busy flag and a done flag. The done flag is read and cleared through a poll strobe, and the result returns one cycle later. While a capture is in flight, the poll returns zero and leaves the flag untouched. The block also counts line-valid rising edges inside each frame and holds the total of the most recent frame in an output register.

Top module: `frame_capture_ctrl`

## Requirements
- R1: After reset, `fifo_wen_o`, `busy_o`, `done_o`, `poll_valid_o`, `poll_done_o` and `last_lines_o` are all 0.
- R2: A request accepted while idle sets `busy_o` on the next clock edge. `fifo_wen_o` stays low until a frame-sync rising edge.
- R3: At a frame-sync rising edge with a request pending, `fifo_wen_o` goes high and `done_o` is cleared.
- R4: At the next frame-sync rising edge (no request pending), `fifo_wen_o` goes low, `busy_o` clears and `done_o` is set. Exactly one frame is written.
- R5: A poll made while `busy_o` is high returns 0 and does not clear `done_o`. This also holds in the cycle where the ending frame-sync edge sets `done_o`.
- R6: A poll made while idle returns the current `done_o` value and clears `done_o`. The result appears on `poll_done_o`, with `poll_valid_o` high, for exactly the one cycle after the strobe.
- R7: A request issued while `busy_o` is high is ignored and never causes a second frame to be written.
- R8: A request that arrives in the same cycle as a detected frame-sync rising edge, while idle, is kept. The capture opens at the following frame-sync rising edge.
- R9: Each line-valid rising edge increments a running count. Each frame-sync rising edge copies the running count to `last_lines_o` and zeroes it. A line edge detected in the same cycle as a frame-sync edge is not counted.
- R10: The running line count saturates at 2**LINE_W-1.
- R11: Both camera inputs pass through SYNC_STAGES flops. With the default of 2, outputs change on the third clock edge after the raw frame-sync input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req_i | input | 1 | One-cycle capture request |
| poll_i | input | 1 | Done poll strobe (read-and-clear) |
| vsync_i | input | 1 | Raw camera frame-sync, asynchronous |
| href_i | input | 1 | Raw camera line-valid, asynchronous |
| fifo_wen_o | output | 1 | Write-enable to the frame FIFO |
| busy_o | output | 1 | Capture armed or in progress |
| done_o | output | 1 | Completed frame not yet polled |
| poll_valid_o | output | 1 | Poll result valid, one cycle after the strobe |
| poll_done_o | output | 1 | Poll result |
| last_lines_o | output | LINE_W | Line count of the previous frame |

## Verification
The poll strobe and the ending frame-sync edge can act in the same cycle. In that cycle, busy is still set when the poll is evaluated, while the edge is setting done. The bench provokes this by raising the poll strobe in exactly the cycle where the synchronised frame-sync edge is detected. It expects a zero poll result, busy cleared and done set, and then a second poll that returns one. Two further pairings are provoked the same way: a request against a frame-sync edge, and a line edge against a frame-sync edge. Each is judged by when the capture opens and by the latched line count.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef struct packed {
    logic req;
    logic busy;
    logic done;
    logic wen;
  } fcc_flags_t;

  localparam fcc_flags_t FCC_FLAGS_RST = '{req: 1'b0, busy: 1'b0, done: 1'b0, wen: 1'b0};
endpackage

// File: rtl/fcc_sync_edge.sv
module fcc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg_q, stg_d;
  logic          prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = async_i;
    end else begin : g_chain
      always_comb stg_d = {stg_q[LAST-1:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[LAST];
    end
  end

  assign rise_o = stg_q[LAST] & ~prev_q;
endmodule

// File: rtl/fcc_line_count.sv
module fcc_line_count #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_rise_i,
  input  logic              frame_rise_i,
  output logic [LINE_W-1:0] last_o
);
  localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q, cnt_d, last_q;
  logic              cnt_en, sat;

  always_comb begin
    sat    = (cnt_q == CNT_MAX);
    cnt_en = frame_rise_i | (line_rise_i & ~sat);
    cnt_d  = frame_rise_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      if (cnt_en)       cnt_q  <= cnt_d;
      if (frame_rise_i) last_q <= cnt_q;
    end
  end

  assign last_o = last_q;

  assert_clear_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise_i |=> (cnt_q == '0 && last_o == $past(cnt_q)));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !frame_rise_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/fcc_capture_ctl.sv
module fcc_capture_ctl
  import fcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic poll_i,
  input  logic frame_rise_i,
  output logic wen_o,
  output logic busy_o,
  output logic done_o,
  output logic poll_valid_o,
  output logic poll_data_o
);
  fcc_flags_t fl_q, fl_d;
  logic       pv_q, pv_d, pd_q, pd_d;

  always_comb begin
    fl_d = fl_q;
    pv_d = poll_i;
    pd_d = 1'b0;
    if (frame_rise_i) begin
      if (fl_q.req) begin
        fl_d.wen  = 1'b1;
        fl_d.done = 1'b0;
        fl_d.req  = 1'b0;
      end else begin
        fl_d.wen = 1'b0;
        if (fl_q.busy) begin
          fl_d.busy = 1'b0;
          fl_d.done = 1'b1;
        end
      end
    end
    if (req_i && !fl_q.busy) begin
      fl_d.req  = 1'b1;
      fl_d.busy = 1'b1;
    end
    if (poll_i) begin
      pd_d = fl_q.busy ? 1'b0 : fl_q.done;
      if (!fl_q.busy) fl_d.done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q <= FCC_FLAGS_RST;
      pv_q <= 1'b0;
      pd_q <= 1'b0;
    end else begin
      fl_q <= fl_d;
      pv_q <= pv_d;
      pd_q <= pd_d;
    end
  end

  assign wen_o        = fl_q.wen;
  assign busy_o       = fl_q.busy;
  assign done_o       = fl_q.done;
  assign poll_valid_o = pv_q;
  assign poll_data_o  = pd_q;

  assert_wen_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wen_o |-> busy_o);

  assert_wen_opens_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_o) |-> ($past(frame_rise_i) && !done_o));

  assert_busy_end_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o && !wen_o));

  assert_poll_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_i && busy_o) |=> (poll_valid_o && !poll_data_o));

  assert_poll_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_i |=> !poll_valid_o);
endmodule

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl #(
  parameter int LINE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req_i,
  input  logic              poll_i,
  input  logic              vsync_i,
  input  logic              href_i,
  output logic              fifo_wen_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              poll_valid_o,
  output logic              poll_done_o,
  output logic [LINE_W-1:0] last_lines_o
);
  localparam int N_CAM = 2;
  localparam int IDX_FRAME = 0;
  localparam int IDX_LINE  = 1;

  logic [N_CAM-1:0] cam_raw, cam_rise;

  assign cam_raw = {href_i, vsync_i};

  generate
    for (genvar i = 0; i < N_CAM; i++) begin : g_sync
      fcc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cam_raw[i]),
        .rise_o (cam_rise[i])
      );
    end
  endgenerate

  fcc_capture_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (cap_req_i),
    .poll_i      (poll_i),
    .frame_rise_i(cam_rise[IDX_FRAME]),
    .wen_o       (fifo_wen_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .poll_valid_o(poll_valid_o),
    .poll_data_o (poll_done_o)
  );

  fcc_line_count #(.LINE_W(LINE_W)) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_rise_i (cam_rise[IDX_LINE]),
    .frame_rise_i(cam_rise[IDX_FRAME]),
    .last_o      (last_lines_o)
  );
endmodule

// File: tb/sim_frame_capture_ctrl.sv
module sim_frame_capture_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 4;

  logic clk, rst_n, cap_req, poll, vsync, href;
  logic wen, busy, done, pvalid, pdone;
  logic [LW-1:0] last_lines;
  int checks = 0;
  int errors = 0;

  frame_capture_ctrl #(.LINE_W(LW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cap_req_i(cap_req), .poll_i(poll),
    .vsync_i(vsync), .href_i(href), .fifo_wen_o(wen), .busy_o(busy),
    .done_o(done), .poll_valid_o(pvalid), .poll_done_o(pdone),
    .last_lines_o(last_lines)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic req_pulse();
    cap_req = 1'b1; tick(1); cap_req = 1'b0;
  endtask

  task automatic vs_rise();
    vsync = 1'b1; tick(3);
  endtask

  task automatic vs_fall();
    vsync = 1'b0; tick(3);
  endtask

  task automatic href_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      href = 1'b1; tick(2); href = 1'b0; tick(2);
    end
    tick(2);
  endtask

  task automatic do_poll(input string rq, input int exp);
    poll = 1'b1; tick(1); poll = 1'b0;
    chk(rq, "poll_valid", pvalid, 1);
    chk(rq, "poll_done", pdone, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cap_req = 0; poll = 0; vsync = 0; href = 0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "wen", wen, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "poll_valid", pvalid, 0);
    chk("R1", "poll_done", pdone, 0);
    chk("R1", "last_lines", last_lines, 0);
  endtask

  task automatic t_single_capture();
    req_pulse();
    chk("R2", "busy", busy, 1);
    chk("R2", "wen", wen, 0);
    tick(4);
    chk("R2", "wen idle", wen, 0);
    vsync = 1'b1; tick(2);
    chk("R11", "wen before 3rd edge", wen, 0);
    tick(1);
    chk("R3", "wen open", wen, 1);
    chk("R3", "done", done, 0);
    vs_fall();
    href_pulses(3);
    vs_rise();
    chk("R4", "wen closed", wen, 0);
    chk("R4", "busy", busy, 0);
    chk("R4", "done", done, 1);
    chk("R9", "last_lines", last_lines, 3);
    vs_fall();
    do_poll("R6", 1);
    chk("R6", "done cleared", done, 0);
    tick(1);
    chk("R6", "poll_valid one cycle", pvalid, 0);
    do_poll("R6", 0);
  endtask

  task automatic t_poll_masked();
    req_pulse(); vs_rise(); vs_fall(); vs_rise(); vs_fall();
    chk("R4", "done pending", done, 1);
    req_pulse();
    do_poll("R5", 0);
    chk("R5", "done kept", done, 1);
    vs_rise();
    chk("R3", "done cleared at open", done, 0);
    chk("R3", "wen", wen, 1);
    vs_fall(); vs_rise(); vs_fall();
    do_poll("R6", 1);
  endtask

  task automatic t_poll_at_end();
    req_pulse(); vs_rise(); vs_fall();
    chk("R3", "wen", wen, 1);
    vsync = 1'b1; tick(2);
    poll = 1'b1; tick(1); poll = 1'b0;
    chk("R5", "poll_valid same cycle", pvalid, 1);
    chk("R5", "poll_done same cycle", pdone, 0);
    chk("R4", "busy", busy, 0);
    chk("R5", "done set", done, 1);
    vs_fall();
    do_poll("R6", 1);
  endtask

  task automatic t_req_while_busy();
    req_pulse(); vs_rise();
    req_pulse();
    vs_fall(); vs_rise();
    chk("R7", "wen closed", wen, 0);
    chk("R7", "busy", busy, 0);
    vs_fall(); vs_rise();
    chk("R7", "no second frame", wen, 0);
    chk("R7", "still idle", busy, 0);
    vs_fall();
    do_poll("R6", 1);
  endtask

  task automatic t_req_on_edge();
    vsync = 1'b1; tick(2);
    cap_req = 1'b1; tick(1); cap_req = 1'b0;
    chk("R8", "wen stays low", wen, 0);
    chk("R8", "busy", busy, 1);
    vs_fall(); vs_rise();
    chk("R8", "wen opens next frame", wen, 1);
    vs_fall(); vs_rise(); vs_fall();
    do_poll("R8", 1);
  endtask

  task automatic t_lines();
    vs_rise(); vs_fall();
    href_pulses(2);
    vsync = 1'b1; href = 1'b1; tick(3);
    chk("R9", "last before coincident", last_lines, 2);
    vsync = 1'b0; href = 1'b0; tick(3);
    vs_rise();
    chk("R9", "coincident line not counted", last_lines, 0);
    vs_fall();
    href_pulses(18);
    vs_rise();
    chk("R10", "saturated count", last_lines, 15);
    vs_fall();
    href_pulses(5);
    vs_rise();
    chk("R9", "restart after saturation", last_lines, 5);
    vs_fall();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_capture();
    t_poll_masked();
    t_poll_at_end();
    t_req_while_busy();
    t_req_on_edge();
    t_lines();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule